// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt activity from three sub-units (a FIFO unit, a timer unit and a display scan-out unit) and turns it into one interrupt request line. Each sub-unit owns a pending register and an enable register. Event pulses from hardware set the sub-unit pending bits, and software clears them by writing ones. A root controller holds one summary bit per sub-unit, its own enable word and the registered request output. The register space also holds a fixed identification word and a display start-address register.

The summary bits are not live. They are recomputed from each sub-unit's pending-and-enabled state only after a write to any pending or enable register, whether at root or at sub-unit level. If an event arrives with no such write behind it, the pending bit is set but the summary and the request stay as they were. The request line tests the whole root pending word and the whole root enable word, each for nonzero. It does not mask them bit by bit.

Access is through a 32-bit register port with separate write and read strobes. The port never stalls. A write takes effect at the clock edge that samples it. A read is accepted every cycle, and its data comes back with `rd_valid` one cycle later. There is no back-pressure, so the requester must take each response in the cycle it appears. Byte offsets: identification 0x000, root pending 0x100, root enable 0x140, FIFO unit pending/enable 0x200/0x204, timer unit 0x300/0x304, display unit 0x400/0x404, display start address 0x408.

Top module: `irq_aggregator`

## Requirements
- R1: A read of offset 0x000 returns the constant 0x02A000A2.
- R2: A write to a sub-unit pending register clears exactly the bits written as one, and the other bits are unchanged.
- R3: A write to a sub-unit enable register replaces its whole value. Only the low SRC_W bits (8 by default) are kept, and reads return them zero-extended.
- R4: A one on a sub-unit event input sets that pending bit at the next clock edge. If a software clear of the same bit lands in the same cycle, the bit ends up set.
- R5: Root pending bit 8 (FIFO), bit 20 (timer) and bit 24 (display) each take the value "sub-unit pending AND enable is nonzero". They are updated one clock after any write to a pending or enable register and at no other time, so events alone leave them stale.
- R6: Root pending is write-one-to-clear, but the recompute that follows the write sets again any summary bit whose sub-unit is still pending and enabled.
- R7: Root enable is a plain 32-bit read/write register.
- R8: `irq` is high exactly when the root pending word is nonzero and the root enable word is nonzero, whichever bits are set in each. It is registered and follows one clock after a change.
- R9: The display start-address register keeps only bits 26:0 of a write, and reads return the masked value.
- R10: A read of an unmapped offset returns zero, and a write to one changes no register.
- R11: `rd_valid` is high exactly one cycle after `rd_en`, with the data in `rd_data`.
- R12: Reset clears all pending, enable and start registers and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| evt | input | 3*SRC_W | Event pulses: FIFO unit [SRC_W-1:0], timer unit next, display unit top |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a summary bit that disagrees with the current sub-unit state. It comes about only when an event lands after the last pending or enable write and no write has followed it. The stimulus reaches it by enabling a source first, then pulsing its event with the port idle. Reads at that point should show the sub-unit bit set while the root pending word and `irq` stay clear. An unrelated root-enable write then forces the recompute. A second constructed case writes a root W1C while the source is still active and confirms that the bit returns. A third drives a software clear and an event onto the same pending bit in the same cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_WD = 12;
  localparam int unsigned N_UNITS = 3;

  localparam logic [REG_W-1:0] CHIP_ID_WORD = 32'h02A0_00A2;
  localparam logic [REG_W-1:0] START_MASK   = 32'h07FF_FFFF;

  localparam int unsigned OFS_ID        = 'h000;
  localparam int unsigned OFS_ROOT_PEND = 'h100;
  localparam int unsigned OFS_ROOT_EN   = 'h140;
  localparam int unsigned OFS_START     = 'h408;
  localparam int unsigned UNIT_BASE     = 'h200;
  localparam int unsigned UNIT_STRIDE   = 'h100;
  localparam int unsigned OFS_PEND      = 'h0;
  localparam int unsigned OFS_EN        = 'h4;

  typedef enum int unsigned {
    SRC_FIFO  = 0,
    SRC_TIMER = 1,
    SRC_SCAN  = 2
  } src_unit_e;

  function automatic int unsigned summary_pos(int unsigned u);
    case (u)
      SRC_FIFO:  return 8;
      SRC_TIMER: return 20;
      default:   return 24;
    endcase
  endfunction

  function automatic int unsigned unit_ofs(int unsigned u, int unsigned reg_ofs);
    return UNIT_BASE + u * UNIT_STRIDE + reg_ofs;
  endfunction
endpackage

// File: rtl/irq_src_unit.sv
module irq_src_unit #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt,
  input  logic             pend_clr_wr,
  input  logic             en_wr,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] pend_q,
  output logic [SRC_W-1:0] en_q,
  output logic             active
);
  logic [SRC_W-1:0] clr_mask;

  always_comb begin
    clr_mask = pend_clr_wr ? wdata : '0;
    active   = |(pend_q & en_q);
  end

  // A hardware set overrides a software clear of the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | evt;
      if (en_wr) en_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_root_ctrl.sv
module irq_root_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_UNITS = N_UNITS,
  parameter int unsigned DATA_W    = REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 recalc,
  input  logic [NUM_UNITS-1:0] unit_active,
  input  logic                 pend_clr_wr,
  input  logic                 en_wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_UNITS-1:0] sum_q,
  output logic [DATA_W-1:0]    en_q,
  output logic [DATA_W-1:0]    pend_word,
  output logic                 irq_q
);
  logic [NUM_UNITS-1:0] clr_bits;
  logic [NUM_UNITS-1:0] sum_d;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_clr
    localparam int unsigned P = summary_pos(u);
    assign clr_bits[u] = wdata[P];
  end

  always_comb begin
    pend_word = '0;
    for (int unsigned u = 0; u < NUM_UNITS; u++) begin
      pend_word[summary_pos(u)] = sum_q[u];
    end
  end

  // The recompute that follows a write wins over a root W1C in the same cycle.
  always_comb begin
    if (recalc)           sum_d = unit_active;
    else if (pend_clr_wr) sum_d = sum_q & ~clr_bits;
    else                  sum_d = sum_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      if (en_wr) en_q <= wdata;
      irq_q <= (|sum_q) && (|en_q);
    end
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int unsigned SRC_W     = 8,
  parameter int unsigned ADDR_W    = ADDR_WD,
  parameter int unsigned NUM_UNITS = N_UNITS,
  parameter int unsigned DATA_W    = REG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NUM_UNITS*SRC_W-1:0] unit_pend_flat,
  input  logic [NUM_UNITS*SRC_W-1:0] unit_en_flat,
  input  logic [DATA_W-1:0]          root_pend_word,
  input  logic [DATA_W-1:0]          root_en,
  output logic [NUM_UNITS-1:0]       unit_pend_wr,
  output logic [NUM_UNITS-1:0]       unit_en_wr,
  output logic                       root_pend_wr,
  output logic                       root_en_wr,
  output logic                       recalc_q,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data
);
  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] rd_mux;
  logic              start_wr;
  logic              any_irq_wr;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
    localparam int unsigned A_PEND = unit_ofs(u, OFS_PEND);
    localparam int unsigned A_EN   = unit_ofs(u, OFS_EN);
    assign unit_pend_wr[u] = wr_en && (wr_addr == ADDR_W'(A_PEND));
    assign unit_en_wr[u]   = wr_en && (wr_addr == ADDR_W'(A_EN));
  end

  assign root_pend_wr = wr_en && (wr_addr == ADDR_W'(OFS_ROOT_PEND));
  assign root_en_wr   = wr_en && (wr_addr == ADDR_W'(OFS_ROOT_EN));
  assign start_wr     = wr_en && (wr_addr == ADDR_W'(OFS_START));
  assign any_irq_wr   = root_pend_wr || root_en_wr || (|unit_pend_wr) || (|unit_en_wr);

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(OFS_ID))        rd_mux = CHIP_ID_WORD;
    if (rd_addr == ADDR_W'(OFS_ROOT_PEND)) rd_mux = root_pend_word;
    if (rd_addr == ADDR_W'(OFS_ROOT_EN))   rd_mux = root_en;
    if (rd_addr == ADDR_W'(OFS_START))     rd_mux = start_q;
    for (int unsigned u = 0; u < NUM_UNITS; u++) begin
      if (rd_addr == ADDR_W'(unit_ofs(u, OFS_PEND)))
        rd_mux = DATA_W'(unit_pend_flat[u*SRC_W +: SRC_W]);
      if (rd_addr == ADDR_W'(unit_ofs(u, OFS_EN)))
        rd_mux = DATA_W'(unit_en_flat[u*SRC_W +: SRC_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      recalc_q <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (start_wr) start_q <= wr_data & START_MASK;
      recalc_q <= any_irq_wr;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned ADDR_W = ADDR_WD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic                     rd_valid,
  output logic [REG_W-1:0]         rd_data,
  input  logic [N_UNITS*SRC_W-1:0] evt,
  output logic                     irq
);
  localparam int unsigned FLAT_W = N_UNITS * SRC_W;

  logic [FLAT_W-1:0]  unit_pend_flat;
  logic [FLAT_W-1:0]  unit_en_flat;
  logic [N_UNITS-1:0] unit_active;
  logic [N_UNITS-1:0] unit_pend_wr;
  logic [N_UNITS-1:0] unit_en_wr;
  logic               root_pend_wr;
  logic               root_en_wr;
  logic               recalc_q;
  logic [N_UNITS-1:0] top_sum;
  logic [REG_W-1:0]   top_en;
  logic [REG_W-1:0]   top_pend_word;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    irq_src_unit #(.SRC_W(SRC_W)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt[u*SRC_W +: SRC_W]),
      .pend_clr_wr(unit_pend_wr[u]),
      .en_wr      (unit_en_wr[u]),
      .wdata      (wr_data[SRC_W-1:0]),
      .pend_q     (unit_pend_flat[u*SRC_W +: SRC_W]),
      .en_q       (unit_en_flat[u*SRC_W +: SRC_W]),
      .active     (unit_active[u])
    );
  end

  irq_root_ctrl #(.NUM_UNITS(N_UNITS), .DATA_W(REG_W)) u_root (
    .clk        (clk),
    .rst_n      (rst_n),
    .recalc     (recalc_q),
    .unit_active(unit_active),
    .pend_clr_wr(root_pend_wr),
    .en_wr      (root_en_wr),
    .wdata      (wr_data),
    .sum_q      (top_sum),
    .en_q       (top_en),
    .pend_word  (top_pend_word),
    .irq_q      (irq)
  );

  irq_reg_port #(
    .SRC_W(SRC_W), .ADDR_W(ADDR_W), .NUM_UNITS(N_UNITS), .DATA_W(REG_W)
  ) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .unit_pend_flat(unit_pend_flat),
    .unit_en_flat  (unit_en_flat),
    .root_pend_word(top_pend_word),
    .root_en       (top_en),
    .unit_pend_wr  (unit_pend_wr),
    .unit_en_wr    (unit_en_wr),
    .root_pend_wr  (root_pend_wr),
    .root_en_wr    (root_en_wr),
    .recalc_q      (recalc_q),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned ADDR_W = ADDR_WD
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic                     rd_valid,
  input logic [REG_W-1:0]         rd_data,
  input logic                     irq,
  input logic [N_UNITS-1:0]       top_sum,
  input logic [REG_W-1:0]         top_en,
  input logic                     recalc,
  input logic [N_UNITS-1:0]       unit_active,
  input logic [N_UNITS*SRC_W-1:0] evt,
  input logic [N_UNITS*SRC_W-1:0] pend_flat
);
  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_id_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(OFS_ID)) |=> (rd_data == CHIP_ID_WORD));
  assert_start_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(OFS_START)) |=> (rd_data[31:27] == 5'd0));
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend_flat & $past(evt)) == $past(evt)));
  assert_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recalc |=> (top_sum == $past(unit_active)));
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(|top_sum) && $past(|top_en))));
endmodule

bind irq_aggregator irq_aggregator_chk #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .irq        (irq),
  .top_sum    (top_sum),
  .top_en     (top_en),
  .recalc     (recalc_q),
  .unit_active(unit_active),
  .evt        (evt),
  .pend_flat  (unit_pend_flat)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SRC_W = 8;
  localparam int ADDR_W = 12;
  localparam int NU = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic [NU*SRC_W-1:0] evt = '0;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .evt(evt), .irq(irq)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        chk(32'h1, 32'h0, "R11 unexpected rd_valid");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rd_data, e.exp, e.tag);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int u, input logic [SRC_W-1:0] b);
    @(negedge clk);
    evt[u*SRC_W +: SRC_W] = b;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R12 reset state, R1 identification
    rd('h000, 32'h02A000A2, "R1 id word");
    rd('h100, 32'h0, "R12 root pend reset");
    rd('h140, 32'h0, "R12 root en reset");
    rd('h200, 32'h0, "R12 fifo pend reset");
    rd('h304, 32'h0, "R12 timer en reset");
    rd('h408, 32'h0, "R12 start reset");
    chk({31'd0, irq}, 32'h0, "R12 irq reset");
    // R11 no response without request
    idle(2);
    chk({31'd0, rd_valid}, 32'h0, "R11 idle rd_valid");
    // R3 enable replace and width
    wr('h204, 32'h0F);  rd('h204, 32'h0F, "R3 enable write");
    wr('h204, 32'hFFFFFFFF); rd('h204, 32'hFF, "R3 enable truncated");
    wr('h204, 32'h01);  rd('h204, 32'h01, "R3 enable replaced");
    // R5 stale summary after event alone
    idle(3);
    pulse(0, 8'h01);
    idle(2);
    rd('h200, 32'h01, "R4 event sets pending");
    rd('h100, 32'h0, "R5 summary stale without write");
    chk({31'd0, irq}, 32'h0, "R5 irq stale low");
    // R7 root enable write triggers recompute
    wr('h140, 32'hFFFFFFFF);
    idle(3);
    rd('h100, 32'h00000100, "R5 fifo summary bit 8");
    rd('h140, 32'hFFFFFFFF, "R7 root enable readback");
    chk({31'd0, irq}, 32'h1, "R8 irq raised");
    // R6 root W1C re-set by recompute
    wr('h100, 32'h00000100);
    idle(3);
    rd('h100, 32'h00000100, "R6 summary re-set after W1C");
    chk({31'd0, irq}, 32'h1, "R6 irq still high");
    // R2 W1C on sub-unit
    pulse(0, 8'h06);
    wr('h200, 32'h05);
    rd('h200, 32'h02, "R2 partial clear");
    idle(3);
    rd('h100, 32'h0, "R5 summary cleared");
    chk({31'd0, irq}, 32'h0, "R8 irq dropped");
    // R4 set wins over same-cycle clear
    pulse(0, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'('h200); wr_data = 32'h03;
    evt[SRC_W-1:0] = 8'h02;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd('h200, 32'h02, "R4 set wins over clear");
    // Timer and display summaries; R8 logical test
    wr('h304, 32'h10);
    pulse(1, 8'h10);
    wr('h404, 32'h01);
    pulse(2, 8'h01);
    wr('h140, 32'h00000001);
    idle(3);
    rd('h100, 32'h01100000, "R5 timer bit 20 display bit 24");
    chk({31'd0, irq}, 32'h1, "R8 whole-word test not mask");
    wr('h140, 32'h0);
    idle(3);
    chk({31'd0, irq}, 32'h0, "R8 enable word zero");
    rd('h100, 32'h01100000, "R7 root pend kept with enable zero");
    wr('h140, 32'h1);
    wr('h400, 32'h01);
    idle(3);
    rd('h100, 32'h00100000, "R5 display bit cleared");
    chk({31'd0, irq}, 32'h1, "R8 timer keeps irq");
    wr('h300, 32'hFF);
    idle(3);
    rd('h100, 32'h0, "R5 all summaries clear");
    chk({31'd0, irq}, 32'h0, "R8 irq low");
    // R9 start address mask
    wr('h408, 32'hFFFFFFFF); rd('h408, 32'h07FFFFFF, "R9 start masked");
    wr('h408, 32'h12345678); rd('h408, 32'h02345678, "R9 start value");
    // R10 unmapped
    rd('h7F0, 32'h0, "R10 unmapped read");
    wr('h7F0, 32'hFFFFFFFF);
    wr('h208, 32'hFF);
    rd('h208, 32'h0, "R10 unmapped read near unit");
    rd('h204, 32'h01, "R10 fifo enable untouched");
    rd('h140, 32'h01, "R10 root enable untouched");
    rd('h408, 32'h02345678, "R10 start untouched");
    rd('h100, 32'h0, "R10 root pend untouched");
    idle(3);
    chk({31'd0, irq}, 32'h0, "R10 irq untouched");
    chk(32'(sb_q.size()), 32'h0, "R11 all reads answered");
    finish_run();
  end
endmodule